// File: doc/BRIEF.md
# Packed Pixel Unpacker

This block sits between a 64-bit video FIFO and the colour stage of a display pipeline. Each FIFO word carries two 32-bit stored words side by side. The block splits them into single pixels and puts out one pixel per enabled pixel-clock cycle on a 24-bit bus. A 3-bit format code sets the pixel depth: 4, 8 or 16 bits per pixel, or 24-bit pixels each held in a 32-bit container. A single position counter advances by one for each pixel. It drives the multiplexer selects and also decides when the next FIFO word is taken. The FIFO is a show-ahead FIFO: its head word is visible while it is not empty, and a read strobe pops it at the clock edge.

In split-screen mode the two 32-bit halves of a word carry pixels for different screen halves. Bits 63:32 hold the upper screen and bits 31:0 hold the lower screen. The block alternates between the halves on its output, starting with the upper half. Within each half it walks the slots in order. A pixel-enable input stalls the counter during blanking. A frame-start pulse drops the word being unpacked and restarts at the first pixel of the next word. A pulse output reports each cycle in which a pixel was demanded but no word was held.

Top module: `pixel_unpacker`

## Requirements
- R1: While `rst` is high, `fifo_rd` is low. In the cycle after a reset edge, `pix_vld`, `pix_out` and `underflow` are all zero.
- R2: With `cfg_mode` = 1 (4 bpp), each word gives 16 pixels. Pixel k comes from bits 4k+3:4k and is zero-extended. A pixel appears on `pix_out` with `pix_vld` high one cycle after the `pix_en` cycle that selects it.
- R3: With `cfg_mode` = 2 (8 bpp), each word gives 8 pixels. Pixel k comes from bits 8k+7:8k and is zero-extended.
- R4: With `cfg_mode` = 3 (16 bpp), each word gives 4 pixels. Pixel k comes from bits 16k+15:16k and is zero-extended.
- R5: With `cfg_mode` = 4 (24 bpp), each word gives 2 pixels. Pixel k is the low 24 bits of the 32-bit container at bits 32k+31:32k.
- R6: With `cfg_dual` high, the pixel count per word is unchanged. Even output positions 2j take slot j of bits 63:32, and odd positions 2j+1 take slot j of bits 31:0. Slots are sized as in R2 to R5.
- R7: `fifo_rd` is high only while `fifo_empty` is low. It is high in two cases: when no word is held, or in an enabled cycle that selects the last pixel of the held word. The popped word is captured on that edge, so with `pix_en` held high, pixels come out on consecutive cycles across word boundaries.
- R8: A cycle with `pix_en` low selects no pixel. In the next cycle `pix_vld` is low and `pix_out` is zero, and the position counter holds.
- R9: A cycle with `pix_en` high and no word held makes `underflow` high for the next cycle only, with `pix_vld` low.
- R10: In a cycle with `frame_start` high, `fifo_rd` is low and no pixel is selected. The held word is discarded, and the next word taken is unpacked from its first pixel.
- R11: Format codes 0, 5, 6 and 7 are invalid. Each such pixel is output as zero, and each word yields one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 3 | Pixel format code |
| cfg_dual | input | 1 | Split-screen interleave enable |
| frame_start | input | 1 | One-cycle pulse that restarts unpacking |
| pix_en | input | 1 | Request for one pixel this cycle |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_word | input | 64 | Head word of the show-ahead FIFO |
| fifo_rd | output | 1 | Pops the head word at this edge |
| pix_out | output | 24 | Unpacked pixel |
| pix_vld | output | 1 | `pix_out` carries a pixel |
| underflow | output | 1 | A pixel was demanded with no word held |

## Verification
The critical collision is the fetch of the next word landing in the same cycle as selection of the last pixel of the current word. The bench provokes it in every format, in both single and split-screen layouts, by holding `pix_en` high across word boundaries and, in some runs, by inserting pauses just before a boundary. For every enabled cycle it predicts whether `fifo_rd` must be high from the count of pixels already seen. It judges the outcome by requiring the next pixel to come from slot zero of the new word on the very next cycle. A second overlap, `frame_start` arriving while a pixel is requested, is judged by the absence of both a pop and an output pixel in that cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int HALF_W  = 32;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int PIX_W   = 24;
    localparam int MIN_BPP = 4;
    localparam int MAX_PPW = WORD_W / MIN_BPP;
    localparam int CNT_W   = $clog2(MAX_PPW);
    localparam int FMT_N   = 4;

    localparam logic [2:0] CODE_4BPP  = 3'd1;
    localparam logic [2:0] CODE_8BPP  = 3'd2;
    localparam logic [2:0] CODE_16BPP = 3'd3;
    localparam logic [2:0] CODE_24BPP = 3'd4;

    typedef enum logic [1:0] {
        FMT_4  = 2'd0,
        FMT_8  = 2'd1,
        FMT_16 = 2'd2,
        FMT_24 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             ok;
        fmt_e             fmt;
        logic [CNT_W-1:0] last;
    } mode_t;

    // Distance between neighbouring pixels inside a word, per format index
    function automatic int fmt_stride(input int g);
        case (g)
            0:       return 4;
            1:       return 8;
            2:       return 16;
            default: return 32;
        endcase
    endfunction

    // Meaningful bits of one pixel, per format index
    function automatic int fmt_bits(input int g);
        case (g)
            0:       return 4;
            1:       return 8;
            2:       return 16;
            default: return PIX_W;
        endcase
    endfunction

    function automatic logic code_ok(input logic [2:0] code);
        return (code == CODE_4BPP) || (code == CODE_8BPP) ||
               (code == CODE_16BPP) || (code == CODE_24BPP);
    endfunction

    function automatic mode_t decode_mode(input logic [2:0] code);
        mode_t m;
        m.ok   = 1'b1;
        m.fmt  = FMT_8;
        m.last = '0;
        case (code)
            CODE_4BPP:  m.fmt = FMT_4;
            CODE_8BPP:  m.fmt = FMT_8;
            CODE_16BPP: m.fmt = FMT_16;
            CODE_24BPP: m.fmt = FMT_24;
            default:    m.ok  = 1'b0;
        endcase
        if (m.ok) begin
            m.last = CNT_W'(WORD_W / fmt_stride(int'(m.fmt)) - 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/pxu_seq.sv
module pxu_seq
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              pix_en,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    input  mode_t             mode,
    output logic              fifo_rd,
    output logic [WORD_W-1:0] word_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              emit,
    output logic              starve
);

    logic have_q;
    logic at_last;
    logic live;

    assign live    = !rst && !frame_start;
    assign at_last = (cnt_q >= mode.last);
    assign emit    = live && pix_en && have_q;
    assign starve  = live && pix_en && !have_q;
    // Fetch when idle, or while the final pixel of the held word is selected
    assign fifo_rd = live && !fifo_empty && (!have_q || (emit && at_last));

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            have_q <= 1'b0;
            cnt_q  <= '0;
            word_q <= '0;
        end else if (fifo_rd) begin
            have_q <= 1'b1;
            cnt_q  <= '0;
            word_q <= fifo_word;
        end else if (emit) begin
            if (at_last) begin
                have_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pxu_select.sv
module pxu_select
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  cnt,
    input  mode_t             mode,
    input  logic              dual,
    output logic [PIX_W-1:0]  pix
);

    logic [WORD_W-1:0] src;
    logic [CNT_W-1:0]  slot;
    logic [PIX_W-1:0]  cand [FMT_N];

    // Split-screen: even positions read the upper half, odd the lower half
    always_comb begin
        if (dual) begin
            src  = {{HALF_W{1'b0}}, (cnt[0] ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W])};
            slot = cnt >> 1;
        end else begin
            src  = word;
            slot = cnt;
        end
    end

    for (genvar g = 0; g < FMT_N; g++) begin : g_fmt
        localparam int STRIDE = fmt_stride(g);
        localparam int BITS   = fmt_bits(g);
        localparam logic [PIX_W-1:0] MASK =
            PIX_W'((WORD_W'(1) << BITS) - WORD_W'(1));
        assign cand[g] = PIX_W'(src >> (int'(slot) * STRIDE)) & MASK;
    end

    assign pix = mode.ok ? cand[mode.fmt] : '0;

endmodule

// File: rtl/pxu_out.sv
module pxu_out
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             emit,
    input  logic             starve,
    input  logic [PIX_W-1:0] pix_sel,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld,
    output logic             underflow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out   <= '0;
            pix_vld   <= 1'b0;
            underflow <= 1'b0;
        end else begin
            pix_out   <= emit ? pix_sel : '0;
            pix_vld   <= emit;
            underflow <= starve;
        end
    end

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_dual,
    input  logic              frame_start,
    input  logic              pix_en,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              fifo_rd,
    output logic [PIX_W-1:0]  pix_out,
    output logic              pix_vld,
    output logic              underflow
);

    mode_t             mode;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              emit;
    logic              starve;
    logic [PIX_W-1:0]  pix_sel;

    assign mode = decode_mode(cfg_mode);

    pxu_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .pix_en      (pix_en),
        .fifo_empty  (fifo_empty),
        .fifo_word   (fifo_word),
        .mode        (mode),
        .fifo_rd     (fifo_rd),
        .word_q      (word_q),
        .cnt_q       (cnt_q),
        .emit        (emit),
        .starve      (starve)
    );

    pxu_select u_sel (
        .word (word_q),
        .cnt  (cnt_q),
        .mode (mode),
        .dual (cfg_dual),
        .pix  (pix_sel)
    );

    pxu_out u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .starve    (starve),
        .pix_sel   (pix_sel),
        .pix_out   (pix_out),
        .pix_vld   (pix_vld),
        .underflow (underflow)
    );

endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk
    import pxu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cfg_mode,
    input logic             frame_start,
    input logic             pix_en,
    input logic             fifo_empty,
    input logic             fifo_rd,
    input logic [PIX_W-1:0] pix_out,
    input logic             pix_vld,
    input logic             underflow
);

    p_reset_rd_r1: assert property (@(posedge clk) rst |-> !fifo_rd);

    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> (!pix_vld && !underflow && pix_out == '0));

    p_rd_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    p_pause_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> (!pix_vld && pix_out == '0));

    p_uflow_excl_r9: assert property (@(posedge clk) disable iff (rst)
        underflow |-> !pix_vld);

    p_uflow_cause_r9: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(pix_en));

    p_fs_no_rd_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !fifo_rd);

    p_fs_no_pix_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !pix_vld);

    p_bad_code_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && !code_ok($past(cfg_mode))) |-> pix_out == '0);

endmodule

bind pixel_unpacker pixel_unpacker_chk chk_i (.*);

// File: tb/pixel_unpacker_tb_top.sv
`timescale 1ns/1ps
module pixel_unpacker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_mode = 3'd2;
    logic        cfg_dual = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_en = 1'b0;
    logic        fifo_empty;
    logic [63:0] fifo_word;
    logic        fifo_rd;
    logic [23:0] pix_out;
    logic        pix_vld;
    logic        underflow;

    logic [63:0] mem [32];
    int          wr_ptr = 0;
    int          rd_ptr = 0;
    logic        fifo_clr = 1'b1;
    int          n_tests = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    // Show-ahead FIFO model
    assign fifo_empty = (rd_ptr >= wr_ptr);
    assign fifo_word  = mem[rd_ptr[4:0]];
    always @(posedge clk) begin
        if (fifo_clr)     rd_ptr <= 0;
        else if (fifo_rd) rd_ptr <= rd_ptr + 1;
    end

    pixel_unpacker dut_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dual(cfg_dual),
        .frame_start(frame_start), .pix_en(pix_en), .fifo_empty(fifo_empty),
        .fifo_word(fifo_word), .fifo_rd(fifo_rd), .pix_out(pix_out),
        .pix_vld(pix_vld), .underflow(underflow)
    );

    typedef struct packed {
        logic [2:0] m;
        logic       d;
        logic [7:0] nw;
        logic [7:0] gap;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 1'b0, 8'd2, 8'd0},
        '{3'd2, 1'b0, 8'd3, 8'd0},
        '{3'd3, 1'b0, 8'd3, 8'd0},
        '{3'd4, 1'b0, 8'd4, 8'd0},
        '{3'd1, 1'b1, 8'd2, 8'd0},
        '{3'd2, 1'b1, 8'd2, 8'd3},
        '{3'd3, 1'b1, 8'd2, 8'd0},
        '{3'd4, 1'b1, 8'd3, 8'd2},
        '{3'd2, 1'b0, 8'd2, 8'd4},
        '{3'd1, 1'b0, 8'd2, 8'd5},
        '{3'd0, 1'b0, 8'd3, 8'd0},
        '{3'd7, 1'b1, 8'd2, 8'd0}
    };

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] gen_word(input int i, input int seed);
        logic [31:0] hi, lo;
        hi = 32'(i + 1) * 32'h13579BDF ^ 32'(seed);
        lo = 32'h2468ACE0 + 32'(i) * 32'h01010101 + 32'(seed) * 32'h00F00F01;
        return {hi, lo};
    endfunction

    function automatic int ppw(input logic [2:0] m);
        case (m)
            3'd1:    return 16;
            3'd2:    return 8;
            3'd3:    return 4;
            3'd4:    return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [23:0] exp_pix(input logic [63:0] w, input logic [2:0] m,
                                            input logic d, input int k);
        int bits, step, pos;
        logic [63:0] t;
        case (m)
            3'd1:    begin bits = 4;  step = 4;  end
            3'd2:    begin bits = 8;  step = 8;  end
            3'd3:    begin bits = 16; step = 16; end
            3'd4:    begin bits = 24; step = 32; end
            default: return 24'd0;
        endcase
        if (d) begin
            t   = (k % 2 == 0) ? {32'd0, w[63:32]} : {32'd0, w[31:0]};
            pos = (k / 2) * step;
        end else begin
            t   = w;
            pos = k * step;
        end
        t = t >> pos;
        return 24'(t & ((64'd1 << bits) - 64'd1));
    endfunction

    function automatic string tag(input logic [2:0] m, input logic d);
        if (!(m >= 3'd1 && m <= 3'd4)) return "R11";
        if (d) return "R6";
        case (m)
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // Pulse frame_start, refill the FIFO model, let the first word preload
    task automatic start_frame(input int nw, input int seed);
        @(negedge clk);
        pix_en      = 1'b0;
        frame_start = 1'b1;
        fifo_clr    = 1'b1;
        for (int i = 0; i < nw; i++) mem[i] = gen_word(i, seed);
        wr_ptr = nw;
        @(negedge clk);
        frame_start = 1'b0;
        fifo_clr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_stream(input logic [2:0] m, input logic d, input int nw,
                              input int gap, input int seed);
        int per, total, got, cyc;
        logic prev_en;
        string rq;
        per   = ppw(m);
        total = nw * per;
        rq    = tag(m, d);
        cfg_mode = m;
        cfg_dual = d;
        start_frame(nw, seed);
        got = 0;
        cyc = 0;
        prev_en = 1'b0;
        while (got < total && cyc < total * 3 + 10) begin
            @(negedge clk);
            if (!prev_en) check("R8", "pixel after paused cycle", {63'd0, pix_vld}, 64'd0);
            if (pix_vld) begin
                check(rq, "pixel value", {40'd0, pix_out},
                      {40'd0, exp_pix(mem[got / per], m, d, got % per)});
                got++;
            end
            if (underflow) check("R9", "unexpected underflow", 64'd1, 64'd0);
            pix_en = (got < total) && !(gap != 0 && (cyc % gap) == gap - 1);
            prev_en = pix_en;
            #1;
            if (pix_en)
                check("R7", "read strobe", {63'd0, fifo_rd},
                      {63'd0, ((got % per) == per - 1) && (got / per + 1 < nw)});
            cyc++;
        end
        pix_en = 1'b0;
        check(rq, "pixels delivered", 64'(got), 64'(total));
        if (gap == 0) check("R7", "no bubble across words", 64'(cyc), 64'(total + 1));
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset state with a non-empty FIFO
        for (int i = 0; i < 2; i++) mem[i] = gen_word(i, 9);
        wr_ptr = 2;
        repeat (3) @(negedge clk);
        fifo_clr = 1'b0;
        #1;
        check("R1", "fifo_rd in reset", {63'd0, fifo_rd}, 64'd0);
        check("R1", "pix_vld in reset", {63'd0, pix_vld}, 64'd0);
        check("R1", "pix_out in reset", {40'd0, pix_out}, 64'd0);
        check("R1", "underflow in reset", {63'd0, underflow}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // Table of format / layout / pause vectors
        for (int v = 0; v < NVEC; v++)
            run_stream(VECS[v].m, VECS[v].d, int'(VECS[v].nw), int'(VECS[v].gap), v + 1);

        // R9: demand with an empty FIFO
        cfg_mode = 3'd2;
        cfg_dual = 1'b0;
        start_frame(0, 0);
        pix_en = 1'b1;
        @(negedge clk);
        check("R9", "underflow raised", {63'd0, underflow}, 64'd1);
        check("R9", "no pixel on underflow", {63'd0, pix_vld}, 64'd0);
        pix_en = 1'b0;
        @(negedge clk);
        check("R9", "underflow lasts one cycle", {63'd0, underflow}, 64'd0);

        // R10: frame_start mid-word discards the partial word
        start_frame(2, 21);
        pix_en = 1'b1;
        repeat (3) @(negedge clk);
        frame_start = 1'b1;
        fifo_clr    = 1'b1;
        mem[0] = gen_word(0, 33);
        wr_ptr = 1;
        #1;
        check("R10", "no read during frame_start", {63'd0, fifo_rd}, 64'd0);
        @(negedge clk);
        check("R10", "no pixel from frame_start cycle", {63'd0, pix_vld}, 64'd0);
        frame_start = 1'b0;
        fifo_clr    = 1'b0;
        pix_en      = 1'b0;
        @(negedge clk);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
        check("R10", "restart at first pixel of new word", {40'd0, pix_out},
              {40'd0, exp_pix(gen_word(0, 33), 3'd2, 1'b0, 0)});
        check("R10", "restart pixel valid", {63'd0, pix_vld}, 64'd1);

        // R8: pause holds the position counter
        start_frame(1, 44);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
        repeat (3) @(negedge clk);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
        check("R8", "pixel after long pause", {40'd0, pix_out},
              {40'd0, exp_pix(gen_word(0, 44), 3'd2, 1'b0, 1)});

        @(negedge clk);
        report();
    end

endmodule